// File: doc/BRIEF.md
# Half-Bridge Gate Oscillator with Dead Time

This block generates the two gate enables of a lamp half-bridge: a low-side enable and a high-side enable that take turns conducting, separated by an interval in which neither conducts. On-phase and dead-interval lengths are counts of clock cycles. Software or a supervising controller supplies the preheat half-period, the run half-period and the dead-time count, and it selects the operating mode. The mode is preheat, ignition or run.

In preheat the on-phases use the shorter preheat count, which gives the higher switching frequency used to warm the filaments. In ignition an internal half-period value starts from the preheat count and walks one count at a time toward the run count, so the frequency glides down instead of jumping. In run mode the run count is used directly. The dead interval keeps the same length in every mode. After each enable the first conducting pulse is on the low side, so that the bootstrap capacitor of the high side is charged first. The block also drives a window flag that marks the low-side on-time, so that over-current samples can be qualified against it. Removing the enable, for example on undervoltage or on a fault, forces both enables low and resets all timing.

All pins are plain control signals. No data stream passes through the block, so none of its ports uses a valid/ready handshake.

Top module: `hb_gate_osc`

## Requirements
- R1: While enabled, the outputs cycle through low-side on, dead, high-side on, dead. Both on-phases of a cycle have the same length: the half-period count in force when each on-phase starts.
- R2: `hs_on` and `ls_on` are never high in the same cycle.
- R3: Each on-phase is followed by exactly `dead_len` cycles with both outputs low, in every mode. When `dead_len` is 0, the other output turns on in the very next cycle.
- R4: Suppose `enable` is sampled high at a clock edge while the block is idle. At that edge `ls_on` rises, and it stays high for a full half-period. The first conducting pulse is never on the high side.
- R5: With `mode` = 0 (preheat), each on-phase lasts `preheat_half` cycles.
- R6: With `mode` = 2 (run) or 3 (treated as run), each on-phase lasts `run_half` cycles.
- R7: With `mode` = 1 (ignition), the half-period value starts from `preheat_half` and moves by one toward `run_half` every RAMP_DIV cycles, then holds at `run_half`. Each on-phase takes the value in force when it starts, so when `run_half` is larger the on-phase widths never decrease and pass through intermediate values.
- R8: At reset, and from the first clock edge at which `enable` is sampled low, both outputs and `ls_window` are low and the phase timing is cleared. The next enable starts again with a full low-side on-phase.
- R9: `ls_window` is high in exactly the cycles in which `ls_on` is high.
- R10: A half-period count of 0 is treated as 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the oscillator; low means lockout or fault |
| mode | input | 2 | 0 preheat, 1 ignition, 2 or 3 run |
| preheat_half | input | HALF_W | Preheat on-phase length in cycles |
| run_half | input | HALF_W | Run on-phase length in cycles |
| dead_len | input | DEAD_W | Dead interval length in cycles |
| hs_on | output | 1 | High-side gate enable |
| ls_on | output | 1 | Low-side gate enable |
| ls_window | output | 1 | Low-side on-time window for current-sense qualification |

## Verification
An enable sampled high at a clock edge raises `ls_on` at that same edge. A disable clears both outputs at the first edge at which it is sampled. Each later transition falls exactly the programmed count of cycles after the previous one. The bench samples on the falling clock edge, half a cycle after each update. From these samples it rebuilds the segments the design produced, each a conducting side plus a length in cycles. It then compares them in order with the segments the driver queued from the programmed counts. For ignition, no fixed timing can be predicted from outside, so the bench checks the order of the observed widths, their start and end values, and the constant dead length. The disable check samples exactly one edge after `enable` drops.

// File: rtl/hb_osc_pkg.sv
package hb_osc_pkg;
  typedef enum logic [1:0] {
    MODE_PREHEAT = 2'd0,
    MODE_IGNITE  = 2'd1,
    MODE_RUN     = 2'd2,
    MODE_RUN_ALT = 2'd3
  } hb_mode_e;

  typedef enum logic [1:0] {
    PH_LOW_ON  = 2'd0,
    PH_DEAD_A  = 2'd1,
    PH_HIGH_ON = 2'd2,
    PH_DEAD_B  = 2'd3
  } hb_phase_e;
endpackage

// File: rtl/hb_half_ramp.sv
module hb_half_ramp
  import hb_osc_pkg::*;
#(
  parameter int HALF_W   = 12,
  parameter int RAMP_DIV = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  hb_mode_e          mode,
  input  logic [HALF_W-1:0] preheat_half,
  input  logic [HALF_W-1:0] run_half,
  output logic [HALF_W-1:0] half_cur
);
  localparam int TICK_W = (RAMP_DIV > 1) ? $clog2(RAMP_DIV) : 1;

  logic step_now;

  generate
    if (RAMP_DIV > 1) begin : g_div
      logic [TICK_W-1:0] tick;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          tick <= '0;
        end else if (!enable || mode != MODE_IGNITE) begin
          tick <= '0;
        end else if (tick == TICK_W'(RAMP_DIV - 1)) begin
          tick <= '0;
        end else begin
          tick <= tick + TICK_W'(1);
        end
      end
      assign step_now = (tick == TICK_W'(RAMP_DIV - 1));
    end else begin : g_nodiv
      assign step_now = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_cur <= '0;
    end else if (!enable) begin
      // idle: preload the value the first on-phase will need
      if (mode == MODE_PREHEAT || mode == MODE_IGNITE) half_cur <= preheat_half;
      else                                             half_cur <= run_half;
    end else if (mode == MODE_PREHEAT) begin
      half_cur <= preheat_half;
    end else if (mode == MODE_IGNITE) begin
      if (step_now) begin
        if (half_cur < run_half)      half_cur <= half_cur + HALF_W'(1);
        else if (half_cur > run_half) half_cur <= half_cur - HALF_W'(1);
      end
    end else begin
      half_cur <= run_half;
    end
  end

  // R7
  ramp_unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && mode == MODE_IGNITE) |=>
      (half_cur == $past(half_cur) ||
       half_cur == $past(half_cur) + HALF_W'(1) ||
       half_cur == $past(half_cur) - HALF_W'(1)));

  // R7
  ramp_hold_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && mode == MODE_IGNITE && half_cur == run_half) |=>
      half_cur == $past(half_cur));
endmodule

// File: rtl/hb_phase_seq.sv
module hb_phase_seq
  import hb_osc_pkg::*;
#(
  parameter int HALF_W = 12,
  parameter int DEAD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [HALF_W-1:0] half_len,
  input  logic [DEAD_W-1:0] dead_len,
  output logic              hs_on,
  output logic              ls_on,
  output logic              ls_window
);
  localparam int CNT_W = (HALF_W > DEAD_W) ? HALF_W : DEAD_W;

  logic            active;
  hb_phase_e       phase;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] seg_len;
  logic [CNT_W:0]   cnt_next;
  logic             seg_end;
  logic             has_dead;

  assign cnt_next = {1'b0, cnt} + (CNT_W+1)'(1);
  // a zero length still ends after one cycle
  assign seg_end  = cnt_next >= {1'b0, seg_len};
  assign has_dead = (dead_len != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      phase   <= PH_LOW_ON;
      cnt     <= '0;
      seg_len <= '0;
    end else if (!enable) begin
      active  <= 1'b0;
      phase   <= PH_LOW_ON;
      cnt     <= '0;
      seg_len <= '0;
    end else if (!active) begin
      active  <= 1'b1;
      phase   <= PH_LOW_ON;
      cnt     <= '0;
      seg_len <= CNT_W'(half_len);
    end else if (seg_end) begin
      cnt <= '0;
      unique case (phase)
        PH_LOW_ON: begin
          if (has_dead) begin
            phase <= PH_DEAD_A; seg_len <= CNT_W'(dead_len);
          end else begin
            phase <= PH_HIGH_ON; seg_len <= CNT_W'(half_len);
          end
        end
        PH_DEAD_A: begin
          phase <= PH_HIGH_ON; seg_len <= CNT_W'(half_len);
        end
        PH_HIGH_ON: begin
          if (has_dead) begin
            phase <= PH_DEAD_B; seg_len <= CNT_W'(dead_len);
          end else begin
            phase <= PH_LOW_ON; seg_len <= CNT_W'(half_len);
          end
        end
        default: begin
          phase <= PH_LOW_ON; seg_len <= CNT_W'(half_len);
        end
      endcase
    end else begin
      cnt <= cnt_next[CNT_W-1:0];
    end
  end

  assign ls_on     = active && (phase == PH_LOW_ON);
  assign hs_on     = active && (phase == PH_HIGH_ON);
  assign ls_window = active && (phase == PH_LOW_ON);

  // R8
  disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!hs_on && !ls_on && !ls_window));

  // R4
  first_pulse_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !active) |=> (ls_on && cnt == '0));

  // R3
  dead_follows_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && active && phase == PH_LOW_ON && seg_end && has_dead) |=>
      (!hs_on && !ls_on));

  // R1
  len_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && active && !seg_end) |=> $stable(seg_len));
endmodule

// File: rtl/hb_gate_osc.sv
module hb_gate_osc
  import hb_osc_pkg::*;
#(
  parameter int HALF_W   = 12,
  parameter int DEAD_W   = 8,
  parameter int RAMP_DIV = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [1:0]        mode,
  input  logic [HALF_W-1:0] preheat_half,
  input  logic [HALF_W-1:0] run_half,
  input  logic [DEAD_W-1:0] dead_len,
  output logic              hs_on,
  output logic              ls_on,
  output logic              ls_window
);
  logic [HALF_W-1:0] half_cur;

  hb_half_ramp #(
    .HALF_W  (HALF_W),
    .RAMP_DIV(RAMP_DIV)
  ) u_ramp (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .mode        (hb_mode_e'(mode)),
    .preheat_half(preheat_half),
    .run_half    (run_half),
    .half_cur    (half_cur)
  );

  hb_phase_seq #(
    .HALF_W(HALF_W),
    .DEAD_W(DEAD_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .half_len (half_cur),
    .dead_len (dead_len),
    .hs_on    (hs_on),
    .ls_on    (ls_on),
    .ls_window(ls_window)
  );

  // R2
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_on && ls_on));
endmodule

// File: tb/hb_gate_osc_bench.sv
module hb_gate_osc_bench;
  localparam int HALF_W = 12;
  localparam int DEAD_W = 8;
  localparam int RDIV   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [HALF_W-1:0] preheat_half = '0;
  logic [HALF_W-1:0] run_half = '0;
  logic [DEAD_W-1:0] dead_len = '0;
  logic hs_on, ls_on, ls_window;

  always #2 clk = ~clk;

  hb_gate_osc #(.HALF_W(HALF_W), .DEAD_W(DEAD_W), .RAMP_DIV(RDIV)) u_hb_gate_osc (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode),
    .preheat_half(preheat_half), .run_half(run_half), .dead_len(dead_len),
    .hs_on(hs_on), .ls_on(ls_on), .ls_window(ls_window));

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // scoreboard queues: code 0 = both off, 1 = low side, 2 = high side
  int exp_code[$];
  int exp_len[$];
  int obs_code[$];
  int obs_len[$];

  bit mon_en = 0;
  bit started = 0;
  int cur_code = 0;
  int cur_len = 0;
  int win_err = 0;
  int both_err = 0;

  always @(negedge clk) begin
    int code;
    code = hs_on ? 2 : (ls_on ? 1 : 0);
    if (!mon_en) begin
      started = 0;
    end else begin
      if (ls_window != ls_on) win_err++;
      if (hs_on && ls_on) both_err++;
      if (!started) begin
        if (code != 0) begin
          started = 1; cur_code = code; cur_len = 1;
        end
      end else if (code == cur_code) begin
        cur_len++;
      end else begin
        obs_code.push_back(cur_code);
        obs_len.push_back(cur_len);
        cur_code = code; cur_len = 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic push_pattern(input int half, input int dd, input int pulses);
    int h;
    h = (half == 0) ? 1 : half;
    for (int i = 0; i < pulses; i++) begin
      exp_code.push_back(1); exp_len.push_back(h);
      if (dd != 0) begin exp_code.push_back(0); exp_len.push_back(dd); end
      exp_code.push_back(2); exp_len.push_back(h);
      if (dd != 0) begin exp_code.push_back(0); exp_len.push_back(dd); end
    end
  endtask

  task automatic compare_all(input string req);
    while (exp_code.size() > 0) begin
      int ec, el;
      ec = exp_code.pop_front();
      el = exp_len.pop_front();
      if (obs_code.size() == 0) begin
        check(0, req, "missing segment", -1, el);
      end else begin
        int oc, ol;
        oc = obs_code.pop_front();
        ol = obs_len.pop_front();
        check(oc == ec, req, "segment side", oc, ec);
        check(ol == el, req, "segment length", ol, el);
      end
    end
    obs_code.delete();
    obs_len.delete();
  endtask

  task automatic stop_run();
    @(negedge clk);
    enable = 1'b0;
    mon_en = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_case(input string req, input int md, input int ph,
                          input int rn, input int dd, input int pulses);
    int h;
    @(negedge clk);
    mode = 2'(md);
    preheat_half = HALF_W'(ph);
    run_half = HALF_W'(rn);
    dead_len = DEAD_W'(dd);
    win_err = 0;
    both_err = 0;
    repeat (2) @(negedge clk);
    h = (md == 0) ? ph : rn;
    push_pattern(h, dd, pulses);
    mon_en = 1;
    enable = 1'b1;
    repeat (pulses * 2 * (((h == 0) ? 1 : h) + dd) + 8) @(negedge clk);
    stop_run();
    compare_all(req);
    check(win_err == 0, "R9", "window mismatches", win_err, 0);
    check(both_err == 0, "R2", "overlap cycles", both_err, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    check(!hs_on && !ls_on && !ls_window, "R8", "outputs in reset",
          int'(hs_on) + int'(ls_on) + int'(ls_window), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!hs_on && !ls_on, "R8", "outputs idle after reset",
          int'(hs_on) + int'(ls_on), 0);

    // R5 R1 R3 R4: preheat alternation with dead time
    run_case("R5", 0, 5, 20, 2, 4);
    // R6: run mode uses run count, wider dead
    run_case("R6", 2, 5, 9, 3, 3);
    // R6: mode 3 behaves as run
    run_case("R6", 3, 5, 7, 1, 2);
    // R3: zero dead time switches directly
    run_case("R3", 2, 4, 6, 0, 3);
    // R10: zero half count gives one-cycle phases
    run_case("R10", 0, 0, 9, 1, 3);
    // R1: minimal half with no dead
    run_case("R1", 2, 3, 1, 0, 4);

    // R8: disable in the middle of a high-side phase, then restart
    @(negedge clk);
    mode = 2'd2; run_half = HALF_W'(6); dead_len = DEAD_W'(1);
    repeat (2) @(negedge clk);
    enable = 1'b1;
    repeat (10) @(negedge clk);
    check(hs_on == 1'b1, "R1", "high side on before disable", int'(hs_on), 1);
    enable = 1'b0;
    @(negedge clk);
    check(!hs_on && !ls_on && !ls_window, "R8", "outputs one edge after disable",
          int'(hs_on) + int'(ls_on) + int'(ls_window), 0);
    repeat (3) @(negedge clk);
    push_pattern(6, 1, 2);
    mon_en = 1;
    enable = 1'b1;
    @(negedge clk);
    // R4: low side conducts first after re-enable
    check(ls_on && !hs_on, "R4", "first pulse side", int'(hs_on) * 2 + int'(ls_on), 1);
    repeat (40) @(negedge clk);
    stop_run();
    compare_all("R8");

    // R7: ignition ramp from preheat 4 to run 12
    @(negedge clk);
    mode = 2'd0; preheat_half = HALF_W'(4); run_half = HALF_W'(12); dead_len = DEAD_W'(2);
    repeat (2) @(negedge clk);
    mon_en = 1;
    enable = 1'b1;
    repeat (60) @(negedge clk);
    mode = 2'd1;
    repeat (400) @(negedge clk);
    stop_run();
    begin
      int widths[$];
      int dead_bad;
      int mono_bad;
      int mid_seen;
      int n;
      dead_bad = 0; mono_bad = 0; mid_seen = 0;
      n = obs_code.size() - 2;  // drop a possibly truncated tail
      for (int i = 0; i < n; i++) begin
        if (obs_code[i] == 0) begin
          if (obs_len[i] != 2) dead_bad++;
        end else begin
          widths.push_back(obs_len[i]);
        end
      end
      for (int i = 1; i < widths.size(); i++)
        if (widths[i] < widths[i-1]) mono_bad++;
      foreach (widths[i])
        if (widths[i] > 4 && widths[i] < 12) mid_seen++;
      check(widths.size() > 20, "R7", "on pulses seen", widths.size(), 21);
      check(widths[0] == 4, "R5", "first width before ignition", widths[0], 4);
      check(mono_bad == 0, "R7", "width decreases", mono_bad, 0);
      check(mid_seen > 0, "R7", "intermediate widths", mid_seen, 1);
      check(widths[widths.size()-1] == 12, "R7", "final width", widths[widths.size()-1], 12);
      check(dead_bad == 0, "R3", "dead length changes in ignition", dead_bad, 0);
      obs_code.delete();
      obs_len.delete();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule